// File: doc/BRIEF.md
# Receive FIFO Watermark and Idle Timer

This block watches the fill levels of a serial port's receive and transmit FIFOs and turns them into the service conditions a host interrupt path needs. It raises a receive trigger once the receive fill count reaches a selectable watermark. It raises a transmit request while the transmit fill count is at or below a second selectable watermark. It raises a receive timeout when data sits in the receive FIFO and no byte has arrived or been taken for a selectable number of character times. Character times are marked by an external one-cycle tick, so the timeout length follows the line rate rather than the core clock.

The block also produces a hardware flow-control line for the link partner. An internal "ready to receive" state drops once the receive fill count reaches a separate four-step threshold, and the line can be inverted. An incoming clear-to-send line is qualified into a transmit-permit output, again with optional inversion. FIFO storage and register decode sit outside the block. Each control field arrives on its own input port.

Top module: `rxw_watch`

## Requirements
- R1: `rx_trig_sel` codes 0,1,2,3,4,5 select receive watermarks of 1,4,8,16,32,48 bytes, and codes 6 and 7 act as 48. `rx_trig` is 1 in the cycle after `rx_level` is at or above the watermark, and 0 otherwise.
- R2: With `tmo_sel` = 0, `rx_tmo` stays 0 whatever the other inputs do.
- R3: `tmo_sel` codes 1,2,3 select 4, 8 and 16 character times. While `rx_level` is non-zero and neither `rx_push` nor `rx_pop` is high, `rx_tmo` rises in the cycle after the Nth `char_tick` pulse and then stays 1.
- R4: A cycle with `rx_push` or `rx_pop` high clears `rx_tmo` in the next cycle and restarts the count from zero.
- R5: While `rx_level` is zero, `rx_tmo` is 0 in the next cycle and ticks are not counted.
- R6: `tx_trig_sel` codes 0,1,2,3 select 0,4,8,16 bytes. `tx_req` is 1 in the cycle after `tx_level` is at or below that value.
- R7: With `rts_en` = 1, `rts_thr_sel` codes 0,1,2,3 select 8,16,32,48 bytes. The ready state is 1 in the cycle after `rx_level` is below the threshold, and 0 in the cycle after it is at or above it.
- R8: With `rts_en` = 0, the ready state is 1 in the next cycle regardless of `rx_level`.
- R9: `rts_out` equals the ready state when `rts_inv` = 0 and its complement when `rts_inv` = 1, with no added delay.
- R10: `tx_allow` is 1 when `cts_en` = 0. Otherwise it equals `cts_in` XOR `cts_inv`, combinationally.
- R11: While `rst` is high, at the following clock edge `rx_trig`, `rx_tmo` and `tx_req` become 0 and the ready state becomes 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_trig_sel | input | 3 | Receive watermark select |
| tx_trig_sel | input | 2 | Transmit watermark select |
| tmo_sel | input | 2 | Idle timeout length select |
| rts_en | input | 1 | Enable receive flow control |
| rts_thr_sel | input | 2 | Flow-control threshold select |
| rts_inv | input | 1 | Invert flow-control output |
| cts_en | input | 1 | Enable clear-to-send qualification |
| cts_inv | input | 1 | Invert clear-to-send input |
| cts_in | input | 1 | Clear-to-send from link partner |
| rx_level | input | LEVEL_W | Receive FIFO fill count |
| tx_level | input | LEVEL_W | Transmit FIFO fill count |
| rx_push | input | 1 | Byte written into receive FIFO |
| rx_pop | input | 1 | Byte read from receive FIFO |
| char_tick | input | 1 | One-cycle pulse per character time |
| rx_trig | output | 1 | Receive watermark reached |
| rx_tmo | output | 1 | Receive idle timeout |
| tx_req | output | 1 | Transmit FIFO needs data |
| rts_out | output | 1 | Flow-control line to link partner |
| tx_allow | output | 1 | Transmitter permitted to send |

## Verification
The bench builds the block with the default `LEVEL_W` of 7, which lets fill counts from 0 up to 127 appear. Every watermark, including the 48-byte top step and the counts just below and just above each one, can therefore be driven directly. Because `char_tick` is a port, the bench drives it on every cycle. The 16-character timeout, the restart after a push or pop, and the hold while empty can all be reached in a few dozen clocks.

// File: rtl/rxw_pkg.sv
package rxw_pkg;

    localparam int THR_W = 8;
    localparam int TMO_W = 5;

    typedef logic [THR_W-1:0] thr_t;
    typedef logic [TMO_W-1:0] tmo_cnt_t;

    typedef enum logic [2:0] {
        RXT_1, RXT_4, RXT_8, RXT_16, RXT_32, RXT_48, RXT_X6, RXT_X7
    } rx_trig_e;

    typedef enum logic [1:0] {TMO_OFF, TMO_4, TMO_8, TMO_16} tmo_e;
    typedef enum logic [1:0] {TXT_EMPTY, TXT_4, TXT_8, TXT_16} tx_trig_e;
    typedef enum logic [1:0] {RTS_8, RTS_16, RTS_32, RTS_48} rts_thr_e;

    typedef struct packed {
        rx_trig_e rx_trig;
        tx_trig_e tx_trig;
        tmo_e     tmo;
        logic     rts_en;
        rts_thr_e rts_thr;
        logic     rts_inv;
        logic     cts_en;
        logic     cts_inv;
    } ctl_t;

    function automatic thr_t rx_watermark(rx_trig_e s);
        case (s)
            RXT_1:   return thr_t'(1);
            RXT_4:   return thr_t'(4);
            RXT_8:   return thr_t'(8);
            RXT_16:  return thr_t'(16);
            RXT_32:  return thr_t'(32);
            default: return thr_t'(48);
        endcase
    endfunction

    function automatic thr_t tx_watermark(tx_trig_e s);
        case (s)
            TXT_EMPTY: return thr_t'(0);
            TXT_4:     return thr_t'(4);
            TXT_8:     return thr_t'(8);
            default:   return thr_t'(16);
        endcase
    endfunction

    function automatic thr_t rts_watermark(rts_thr_e s);
        case (s)
            RTS_8:   return thr_t'(8);
            RTS_16:  return thr_t'(16);
            RTS_32:  return thr_t'(32);
            default: return thr_t'(48);
        endcase
    endfunction

    function automatic tmo_cnt_t idle_limit(tmo_e s);
        case (s)
            TMO_4:   return tmo_cnt_t'(4);
            TMO_8:   return tmo_cnt_t'(8);
            TMO_16:  return tmo_cnt_t'(16);
            default: return tmo_cnt_t'(0);
        endcase
    endfunction

endpackage

// File: rtl/rxw_level_cmp.sv
module rxw_level_cmp
    import rxw_pkg::*;
#(
    parameter int LEVEL_W = 7
) (
    input  logic               clk,
    input  logic               rst,
    input  rx_trig_e           rx_sel,
    input  tx_trig_e           tx_sel,
    input  logic [LEVEL_W-1:0] rx_level,
    input  logic [LEVEL_W-1:0] tx_level,
    output logic               rx_trig,
    output logic               tx_req
);
    localparam int CW = (LEVEL_W > THR_W) ? LEVEL_W : THR_W;

    logic [CW-1:0] rx_lvl_x, tx_lvl_x, rx_thr_x, tx_thr_x;

    assign rx_lvl_x = CW'(rx_level);
    assign tx_lvl_x = CW'(tx_level);
    assign rx_thr_x = CW'(rx_watermark(rx_sel));
    assign tx_thr_x = CW'(tx_watermark(tx_sel));

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_trig <= 1'b0;
            tx_req  <= 1'b0;
        end else begin
            rx_trig <= (rx_lvl_x >= rx_thr_x);
            tx_req  <= (tx_lvl_x <= tx_thr_x);
        end
    end

    // Smallest watermark is one byte: an empty FIFO never triggers.
    assert_trig_nonempty_R1: assert property (@(posedge clk) disable iff (rst)
        rx_trig |-> ($past(rx_level) != '0));

    // Largest transmit watermark is 16 bytes.
    assert_txreq_bound_R6: assert property (@(posedge clk) disable iff (rst)
        tx_req |-> ($past(tx_level) <= LEVEL_W'(16)));

endmodule

// File: rtl/rxw_idle_timer.sv
module rxw_idle_timer
    import rxw_pkg::*;
#(
    parameter int LEVEL_W = 7
) (
    input  logic               clk,
    input  logic               rst,
    input  tmo_e               tmo_sel,
    input  logic [LEVEL_W-1:0] rx_level,
    input  logic               rx_push,
    input  logic               rx_pop,
    input  logic               char_tick,
    output logic               rx_tmo
);
    tmo_cnt_t limit, cnt, cnt_nxt;
    logic     restart;

    assign limit   = idle_limit(tmo_sel);
    assign cnt_nxt = cnt + 1'b1;
    assign restart = (limit == '0) || (rx_level == '0) || rx_push || rx_pop;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt    <= '0;
            rx_tmo <= 1'b0;
        end else if (restart) begin
            cnt    <= '0;
            rx_tmo <= 1'b0;
        end else if (char_tick && !rx_tmo) begin
            cnt <= cnt_nxt;
            if (cnt_nxt >= limit) rx_tmo <= 1'b1;
        end
    end

    assert_tmo_off_R2: assert property (@(posedge clk) disable iff (rst)
        (tmo_sel == TMO_OFF) |=> !rx_tmo);

    assert_tmo_on_tick_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(rx_tmo) |-> $past(char_tick));

    assert_tmo_clear_R4: assert property (@(posedge clk) disable iff (rst)
        (rx_push || rx_pop) |=> !rx_tmo);

    assert_tmo_empty_R5: assert property (@(posedge clk) disable iff (rst)
        (rx_level == '0) |=> !rx_tmo);

endmodule

// File: rtl/rxw_flow_ctl.sv
module rxw_flow_ctl
    import rxw_pkg::*;
#(
    parameter int LEVEL_W = 7
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               rts_en,
    input  rts_thr_e           rts_thr,
    input  logic               rts_inv,
    input  logic               cts_en,
    input  logic               cts_inv,
    input  logic               cts_in,
    input  logic [LEVEL_W-1:0] rx_level,
    output logic               rts_out,
    output logic               tx_allow
);
    localparam int CW = (LEVEL_W > THR_W) ? LEVEL_W : THR_W;

    logic          ready;
    logic [CW-1:0] lvl_x, thr_x;

    assign lvl_x = CW'(rx_level);
    assign thr_x = CW'(rts_watermark(rts_thr));

    always_ff @(posedge clk) begin
        if (rst)          ready <= 1'b1;
        else if (!rts_en) ready <= 1'b1;
        else              ready <= (lvl_x < thr_x);
    end

    assign rts_out  = ready ^ rts_inv;
    assign tx_allow = !cts_en || (cts_in ^ cts_inv);

    // Lowest threshold is 8 bytes: below it the partner is always let through.
    assert_ready_low_R7: assert property (@(posedge clk) disable iff (rst)
        ($past(rx_level) < LEVEL_W'(8)) |-> ready);

    assert_ready_dis_R8: assert property (@(posedge clk) disable iff (rst)
        !rts_en |=> ready);

endmodule

// File: rtl/rxw_watch.sv
module rxw_watch
    import rxw_pkg::*;
#(
    parameter int LEVEL_W = 7
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [2:0]         rx_trig_sel,
    input  logic [1:0]         tx_trig_sel,
    input  logic [1:0]         tmo_sel,
    input  logic               rts_en,
    input  logic [1:0]         rts_thr_sel,
    input  logic               rts_inv,
    input  logic               cts_en,
    input  logic               cts_inv,
    input  logic               cts_in,
    input  logic [LEVEL_W-1:0] rx_level,
    input  logic [LEVEL_W-1:0] tx_level,
    input  logic               rx_push,
    input  logic               rx_pop,
    input  logic               char_tick,
    output logic               rx_trig,
    output logic               rx_tmo,
    output logic               tx_req,
    output logic               rts_out,
    output logic               tx_allow
);
    ctl_t ctl;

    assign ctl.rx_trig = rx_trig_e'(rx_trig_sel);
    assign ctl.tx_trig = tx_trig_e'(tx_trig_sel);
    assign ctl.tmo     = tmo_e'(tmo_sel);
    assign ctl.rts_en  = rts_en;
    assign ctl.rts_thr = rts_thr_e'(rts_thr_sel);
    assign ctl.rts_inv = rts_inv;
    assign ctl.cts_en  = cts_en;
    assign ctl.cts_inv = cts_inv;

    rxw_level_cmp #(.LEVEL_W(LEVEL_W)) u_cmp (
        .clk(clk), .rst(rst),
        .rx_sel(ctl.rx_trig), .tx_sel(ctl.tx_trig),
        .rx_level(rx_level), .tx_level(tx_level),
        .rx_trig(rx_trig), .tx_req(tx_req)
    );

    rxw_idle_timer #(.LEVEL_W(LEVEL_W)) u_tmo (
        .clk(clk), .rst(rst), .tmo_sel(ctl.tmo),
        .rx_level(rx_level), .rx_push(rx_push), .rx_pop(rx_pop),
        .char_tick(char_tick), .rx_tmo(rx_tmo)
    );

    rxw_flow_ctl #(.LEVEL_W(LEVEL_W)) u_flow (
        .clk(clk), .rst(rst),
        .rts_en(ctl.rts_en), .rts_thr(ctl.rts_thr), .rts_inv(ctl.rts_inv),
        .cts_en(ctl.cts_en), .cts_inv(ctl.cts_inv), .cts_in(cts_in),
        .rx_level(rx_level), .rts_out(rts_out), .tx_allow(tx_allow)
    );

endmodule

// File: tb/rxw_watch_tb.sv
module rxw_watch_tb_top;
    localparam int LW = 7;
    localparam int NV = 15;

    // {rx_sel[3], rts_sel[2], tx_sel[2], rx_lvl[7], tx_lvl[7], trig, txreq, ready}
    localparam logic [23:0] VEC [NV] = '{
        {3'd0, 2'd0, 2'd0, 7'd0,  7'd0,  1'b0, 1'b1, 1'b1},
        {3'd0, 2'd0, 2'd1, 7'd1,  7'd4,  1'b1, 1'b1, 1'b1},
        {3'd1, 2'd1, 2'd1, 7'd3,  7'd5,  1'b0, 1'b0, 1'b1},
        {3'd1, 2'd0, 2'd2, 7'd4,  7'd8,  1'b1, 1'b1, 1'b1},
        {3'd2, 2'd0, 2'd2, 7'd7,  7'd9,  1'b0, 1'b0, 1'b1},
        {3'd2, 2'd0, 2'd3, 7'd8,  7'd16, 1'b1, 1'b1, 1'b0},
        {3'd3, 2'd1, 2'd3, 7'd15, 7'd17, 1'b0, 1'b0, 1'b1},
        {3'd3, 2'd1, 2'd0, 7'd16, 7'd1,  1'b1, 1'b0, 1'b0},
        {3'd4, 2'd2, 2'd0, 7'd31, 7'd0,  1'b0, 1'b1, 1'b1},
        {3'd4, 2'd2, 2'd3, 7'd32, 7'd0,  1'b1, 1'b1, 1'b0},
        {3'd5, 2'd3, 2'd2, 7'd47, 7'd3,  1'b0, 1'b1, 1'b1},
        {3'd5, 2'd3, 2'd2, 7'd48, 7'd3,  1'b1, 1'b1, 1'b0},
        {3'd6, 2'd3, 2'd2, 7'd47, 7'd3,  1'b0, 1'b1, 1'b1},
        {3'd7, 2'd3, 2'd2, 7'd48, 7'd3,  1'b1, 1'b1, 1'b0},
        {3'd7, 2'd2, 2'd2, 7'd64, 7'd3,  1'b1, 1'b1, 1'b0}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [2:0] rx_trig_sel = '0;
    logic [1:0] tx_trig_sel = '0, tmo_sel = '0, rts_thr_sel = '0;
    logic rts_en = 1'b1, rts_inv = 1'b0, cts_en = 1'b0, cts_inv = 1'b0, cts_in = 1'b0;
    logic [LW-1:0] rx_level = '0, tx_level = '0;
    logic rx_push = 1'b0, rx_pop = 1'b0, char_tick = 1'b0;
    logic rx_trig, rx_tmo, tx_req, rts_out, tx_allow;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    rxw_watch #(.LEVEL_W(LW)) dut_i (
        .clk(clk), .rst(rst),
        .rx_trig_sel(rx_trig_sel), .tx_trig_sel(tx_trig_sel), .tmo_sel(tmo_sel),
        .rts_en(rts_en), .rts_thr_sel(rts_thr_sel), .rts_inv(rts_inv),
        .cts_en(cts_en), .cts_inv(cts_inv), .cts_in(cts_in),
        .rx_level(rx_level), .tx_level(tx_level),
        .rx_push(rx_push), .rx_pop(rx_pop), .char_tick(char_tick),
        .rx_trig(rx_trig), .rx_tmo(rx_tmo), .tx_req(tx_req),
        .rts_out(rts_out), .tx_allow(tx_allow)
    );

    task automatic check(string req, logic got, logic exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %0b expected %0b", req, got, exp);
        end
    endtask

    task automatic ticks(int n);
        for (int i = 0; i < n; i++) begin
            char_tick = 1'b1;
            @(negedge clk);
        end
        char_tick = 1'b0;
    endtask

    task automatic pulse_push();
        rx_push = 1'b1;
        @(negedge clk);
        rx_push = 1'b0;
    endtask

    task automatic pulse_pop();
        rx_pop = 1'b1;
        @(negedge clk);
        rx_pop = 1'b0;
    endtask

    initial begin
        // R11: reset values
        @(negedge clk);
        @(negedge clk);
        check("R11 rx_trig", rx_trig, 1'b0);
        check("R11 rx_tmo", rx_tmo, 1'b0);
        check("R11 tx_req", tx_req, 1'b0);
        check("R11 rts_out", rts_out, 1'b1);
        rst = 1'b0;

        // R1 R6 R7: watermark table
        for (int v = 0; v < NV; v++) begin
            rx_trig_sel = VEC[v][23:21];
            rts_thr_sel = VEC[v][20:19];
            tx_trig_sel = VEC[v][18:17];
            rx_level    = VEC[v][16:10];
            tx_level    = VEC[v][9:3];
            @(negedge clk);
            check($sformatf("R1 vec %0d", v), rx_trig, VEC[v][2]);
            check($sformatf("R6 vec %0d", v), tx_req, VEC[v][1]);
            check($sformatf("R7 vec %0d", v), rts_out, VEC[v][0]);
        end

        // R9: inversion of the flow-control line
        rts_inv = 1'b1; rts_thr_sel = 2'd0; rx_level = 7'd2;
        @(negedge clk);
        check("R9 inv ready", rts_out, 1'b0);
        rx_level = 7'd8;
        @(negedge clk);
        check("R9 inv full", rts_out, 1'b1);
        rts_inv = 1'b0;

        // R8: disabled flow control keeps ready
        rts_en = 1'b0; rx_level = 7'd60;
        @(negedge clk);
        check("R8 disabled", rts_out, 1'b1);
        rts_en = 1'b1;

        // R10: clear-to-send qualification
        cts_en = 1'b0; cts_in = 1'b0; #1;
        check("R10 off", tx_allow, 1'b1);
        cts_en = 1'b1; #1;
        check("R10 low", tx_allow, 1'b0);
        cts_in = 1'b1; #1;
        check("R10 high", tx_allow, 1'b1);
        cts_inv = 1'b1; #1;
        check("R10 inv", tx_allow, 1'b0);
        @(negedge clk);

        // R3: 4 character times
        rx_level = 7'd5; tmo_sel = 2'd1;
        pulse_push();
        ticks(3);
        check("R3 4ch early", rx_tmo, 1'b0);
        ticks(1);
        check("R3 4ch fire", rx_tmo, 1'b1);
        ticks(3);
        check("R3 4ch hold", rx_tmo, 1'b1);

        // R4: push clears, count restarts
        pulse_push();
        check("R4 push clear", rx_tmo, 1'b0);
        ticks(3);
        pulse_push();
        ticks(3);
        check("R4 restart", rx_tmo, 1'b0);
        ticks(1);
        check("R4 after restart", rx_tmo, 1'b1);
        pulse_pop();
        check("R4 pop clear", rx_tmo, 1'b0);

        // R3: 16 and 8 character times
        tmo_sel = 2'd3;
        pulse_push();
        ticks(15);
        check("R3 16ch early", rx_tmo, 1'b0);
        ticks(1);
        check("R3 16ch fire", rx_tmo, 1'b1);
        tmo_sel = 2'd2;
        pulse_push();
        ticks(7);
        check("R3 8ch early", rx_tmo, 1'b0);
        ticks(1);
        check("R3 8ch fire", rx_tmo, 1'b1);

        // R5: empty FIFO clears and holds
        rx_level = '0;
        @(negedge clk);
        check("R5 empty clear", rx_tmo, 1'b0);
        ticks(20);
        check("R5 empty hold", rx_tmo, 1'b0);
        rx_level = 7'd3;
        ticks(7);
        check("R5 count from zero", rx_tmo, 1'b0);

        // R2: disabled timeout
        tmo_sel = 2'd0;
        ticks(20);
        check("R2 disabled", rx_tmo, 1'b0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(20 * 20000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got hang expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule